// File: doc/BRIEF.md
# Word-serial register access bridge

This block lets a host reach a remote register space with a 24-bit address through only two host-visible locations: a transfer register and a status register. Every access is serialized through the transfer register. The host writes a command word that packs an opcode in its top byte and a target address in the low 24 bits. For a write it follows up with one data word. It then polls a ready flag in the status register. Once the flag is set, it drains the response from the transfer register: first a status word, then the register value if the command was a read. The ready flag drops once the last response word has been consumed.

On the far side the bridge drives a simple internal register bus. It holds an address and write data, raises a one-cycle read or write strobe, and waits for a done pulse that brings back read data and an error flag. The sequencing is a six-state machine:
- `ST_IDLE`: waiting for a command.
- `ST_WDATA`: a write command is held until its data word arrives.
- `ST_ISSUE`: one cycle with the strobe raised.
- `ST_WAIT`: waiting for done.
- `ST_RSTAT`: status word pending, ready set.
- `ST_RDATA`: read value pending, ready set.

The named transitions are:
- accept-read: `ST_IDLE` to `ST_ISSUE`.
- accept-write: `ST_IDLE` to `ST_WDATA`.
- reject: `ST_IDLE` to `ST_RSTAT` on an unknown opcode.
- data-in: `ST_WDATA` to `ST_ISSUE`.
- strobe: `ST_ISSUE` to `ST_WAIT`.
- complete: `ST_WAIT` to `ST_RSTAT` on done.
- pop-status: from `ST_RSTAT`, to `ST_RDATA` for a read or to `ST_IDLE` otherwise.
- pop-data: `ST_RDATA` to `ST_IDLE`.

A host that finds ready already set before a new command drains the stale words by reading the transfer register until ready clears.

Top module: `wsb_bridge`

## Requirements
- R1: A command word is taken from a transfer-register write while idle. The opcode is bits 31:24 and the target address is bits 23:0. That address appears on `bus_addr` while the strobe is raised.
- R2: Opcode 0x01 raises `bus_re` for exactly one cycle, the cycle after the command is accepted. Opcode 0x10 waits for the next transfer-register write and takes it as data. It then raises `bus_we` for exactly one cycle with that word on `bus_wdata`. The two strobes are never high together.
- R3: Any other opcode raises no strobe. The ready flag is set in the cycle after the command. The status word is 0x00000002 and no data word follows.
- R4: A read of the status register (`host_sel`=1) returns the ready flag in bit 0 and zeros in all other bits. Ready rises in the cycle after `bus_done` is sampled high.
- R5: While ready is set, the first transfer-register read returns the status word. For opcode 0x01, the second returns the `bus_rdata` value captured with `bus_done`. Ready clears after the last word is read.
- R6: The status word is 0x00000000 when the bus completed without error. Bit 0 is set when `bus_err` was high with `bus_done`.
- R7: A transfer-register write while a command is in progress (strobe, waiting for done, or response pending) is ignored and raises no strobe. It sets bit 2 of the next status word returned, and that bit clears once that status word has been read.
- R8: Each transfer-register read while ready is set discards exactly one pending word, and ready stays set until the last word goes. A transfer-register read while ready is clear returns 0 and changes nothing.
- R9: A write to the status register has no effect: no strobe, and ready stays clear.
- R10: After reset the bridge is idle, ready is clear, both strobes are low and transfer reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Host location select: 0 transfer register, 1 status register |
| host_wr | input | 1 | Host write strobe, one cycle per word |
| host_rd | input | 1 | Host read strobe, one cycle per word; consumes a pending word on the transfer register |
| host_wdata | input | 32 | Host write word (command or data) |
| host_rdata | output | 32 | Host read word for the selected location, valid in the cycle of the read |
| bus_addr | output | 24 | Internal bus address |
| bus_wdata | output | 32 | Internal bus write data |
| bus_we | output | 1 | Internal bus write strobe, one cycle |
| bus_re | output | 1 | Internal bus read strobe, one cycle |
| bus_rdata | input | 32 | Internal bus read data, valid with bus_done |
| bus_done | input | 1 | Internal bus completion pulse, earliest the cycle after the strobe |
| bus_err | input | 1 | Internal bus error flag, valid with bus_done |

## Verification
The bench drives commands at several bus latencies and goes after the following cases:
- **Unknown opcode.** A bridge that forwarded it would show a stray strobe. One that queued a data word would keep ready set for an extra read.
- **Command during a busy phase.** A second command arriving while one is in progress is the overrun case. A design that accepted it would either corrupt the remote register or lose the overrun bit from the status word.
- **Partial and full drains, and the ordering of responses.** These catch a response order swapped between status and data, and ready dropping a word early. They also catch a transfer read while idle that disturbs the machine.
- **Writes to the status register, and reads during the data wait of a write.** A design that decoded these would start spurious accesses.

// File: rtl/wsb_pkg.sv
package wsb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WDATA,
        ST_ISSUE,
        ST_WAIT,
        ST_RSTAT,
        ST_RDATA
    } wsb_state_t;

    // status word bit positions
    localparam int STB_BUSERR = 0;
    localparam int STB_BADOP  = 1;
    localparam int STB_OVR    = 2;

endpackage

// File: rtl/wsb_decode.sv
module wsb_decode #(
    parameter int DATA_W = 32,
    parameter int OPC_W  = 8,
    parameter int OP_RD  = 1,
    parameter int OP_WR  = 16,
    localparam int ADDR_W = DATA_W - OPC_W
) (
    input  logic [DATA_W-1:0] cmd,
    output logic              is_rd,
    output logic              is_wr,
    output logic              is_bad,
    output logic [ADDR_W-1:0] addr
);

    logic [OPC_W-1:0] opc;

    always_comb begin
        opc    = cmd[DATA_W-1 -: OPC_W];
        addr   = cmd[ADDR_W-1:0];
        is_rd  = (opc == OPC_W'(OP_RD));
        is_wr  = (opc == OPC_W'(OP_WR));
        is_bad = !(is_rd || is_wr);
    end

endmodule

// File: rtl/wsb_resp.sv
module wsb_resp #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_bus,
    input  logic              bus_err,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              ld_bad,
    input  logic              set_ovr,
    input  logic              pop_stat,
    output logic [DATA_W-1:0] stat_word,
    output logic [DATA_W-1:0] data_word
);
    import wsb_pkg::*;

    logic [1:0]        code_q;
    logic [DATA_W-1:0] data_q;
    logic              ovr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            data_q <= '0;
            ovr_q  <= 1'b0;
        end else begin
            if (ld_bus) begin
                code_q <= {1'b0, bus_err};
                data_q <= bus_rdata;
            end else if (ld_bad) begin
                code_q <= 2'b10;
            end
            if (set_ovr) begin
                ovr_q <= 1'b1;
            end else if (pop_stat) begin
                ovr_q <= 1'b0;
            end
        end
    end

    always_comb begin
        stat_word = '0;
        stat_word[STB_BUSERR] = code_q[0];
        stat_word[STB_BADOP]  = code_q[1];
        stat_word[STB_OVR]    = ovr_q;
        data_word = data_q;
    end

endmodule

// File: rtl/wsb_bridge.sv
module wsb_bridge #(
    parameter int DATA_W = 32,
    parameter int OPC_W  = 8,
    parameter int OP_RD  = 1,
    parameter int OP_WR  = 16,
    localparam int ADDR_W = DATA_W - OPC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_we,
    output logic              bus_re,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_done,
    input  logic              bus_err
);
    import wsb_pkg::*;

    wsb_state_t st, nxt;

    logic              xfer_wr, xfer_rd;
    logic              dec_rd, dec_wr, dec_bad;
    logic [ADDR_W-1:0] dec_addr;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              rd_q;
    logic              is_ready, is_idle, is_busy;
    logic [DATA_W-1:0] stat_word, data_word;

    assign xfer_wr = host_wr && !host_sel;
    assign xfer_rd = host_rd && !host_sel;

    wsb_decode #(
        .DATA_W(DATA_W), .OPC_W(OPC_W), .OP_RD(OP_RD), .OP_WR(OP_WR)
    ) u_dec (
        .cmd   (host_wdata),
        .is_rd (dec_rd),
        .is_wr (dec_wr),
        .is_bad(dec_bad),
        .addr  (dec_addr)
    );

    wsb_resp #(.DATA_W(DATA_W)) u_resp (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_bus   (st == ST_WAIT && bus_done),
        .bus_err  (bus_err),
        .bus_rdata(bus_rdata),
        .ld_bad   (st == ST_IDLE && xfer_wr && dec_bad),
        .set_ovr  (xfer_wr && is_busy),
        .pop_stat (st == ST_RSTAT && xfer_rd),
        .stat_word(stat_word),
        .data_word(data_word)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // next state
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE: begin
                if (xfer_wr) begin
                    if (dec_rd)      nxt = ST_ISSUE;
                    else if (dec_wr) nxt = ST_WDATA;
                    else             nxt = ST_RSTAT;
                end
            end
            ST_WDATA: if (xfer_wr)  nxt = ST_ISSUE;
            ST_ISSUE:               nxt = ST_WAIT;
            ST_WAIT:  if (bus_done) nxt = ST_RSTAT;
            ST_RSTAT: if (xfer_rd)  nxt = rd_q ? ST_RDATA : ST_IDLE;
            ST_RDATA: if (xfer_rd)  nxt = ST_IDLE;
            default:                nxt = ST_IDLE;
        endcase
    end

    // command and data capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rd_q    <= 1'b0;
        end else begin
            if (st == ST_IDLE && xfer_wr) begin
                addr_q <= dec_addr;
                rd_q   <= dec_rd;
            end
            if (st == ST_WDATA && xfer_wr) begin
                wdata_q <= host_wdata;
            end
        end
    end

    // outputs
    always_comb begin
        is_idle    = (st == ST_IDLE);
        is_ready   = (st == ST_RSTAT) || (st == ST_RDATA);
        is_busy    = (st == ST_ISSUE) || (st == ST_WAIT) || is_ready;
        bus_addr   = addr_q;
        bus_wdata  = wdata_q;
        bus_re     = (st == ST_ISSUE) && rd_q;
        bus_we     = (st == ST_ISSUE) && !rd_q;
        host_rdata = '0;
        if (host_sel)              host_rdata[0] = is_ready;
        else if (st == ST_RSTAT)   host_rdata = stat_word;
        else if (st == ST_RDATA)   host_rdata = data_word;
    end

endmodule

// File: rtl/wsb_bridge_chk.sv
module wsb_bridge_chk #(
    parameter int OPC_W = 8,
    parameter int OP_RD = 1,
    parameter int OP_WR = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_sel,
    input logic             host_wr,
    input logic             host_rd,
    input logic [OPC_W-1:0] opc,
    input logic             bus_re,
    input logic             bus_we,
    input logic             ready,
    input logic             idle
);

    logic cmd_now, opc_bad;
    assign cmd_now = idle && host_wr && !host_sel;
    assign opc_bad = (opc != OPC_W'(OP_RD)) && (opc != OPC_W'(OP_WR));

    p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_re && bus_we));

    p_re_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_re |=> !bus_re);

    p_we_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |=> !bus_we);

    p_rd_issue_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_now && opc == OPC_W'(OP_RD) |=> bus_re);

    p_badop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_now && opc_bad |=> ready && !bus_re && !bus_we);

    p_quiet_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !(bus_re || bus_we));

    p_ready_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ready && !(host_rd && !host_sel) |=> ready);

    p_stat_wr_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        idle && host_wr && host_sel |=> idle);

endmodule

bind wsb_bridge wsb_bridge_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .host_sel(host_sel),
    .host_wr (host_wr),
    .host_rd (host_rd),
    .opc     (host_wdata[31:24]),
    .bus_re  (bus_re),
    .bus_we  (bus_we),
    .ready   (is_ready),
    .idle    (is_idle)
);

// File: tb/sim_wsb_bridge.sv
`timescale 1ns/1ps
module sim_wsb_bridge;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_sel = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [23:0] bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_we, bus_re;
    logic [31:0] bus_rdata = '0;
    logic        bus_done = 1'b0, bus_err = 1'b0;

    int checks = 0;
    int errs   = 0;
    int lat    = 0;
    bit done_f = 0;

    always #5 clk = ~clk;

    wsb_bridge u0 (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
        .bus_re(bus_re), .bus_rdata(bus_rdata), .bus_done(bus_done),
        .bus_err(bus_err)
    );

    function automatic logic [31:0] dflt(input logic [23:0] a);
        return {8'h5A, a} ^ {a, 8'h3C};
    endfunction

    function automatic bit bad_addr(input logic [23:0] a);
        return a[23:20] == 4'hF;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s: got %08h expected %08h at %0t", tag, got, exp, $time);
        end
    endtask

    // ---------------- bus responder ----------------
    logic [31:0] b_mem [int];
    bit          b_pend = 0, b_isrd = 0;
    int          b_cnt = 0;
    logic [23:0] b_addr = '0;

    always @(posedge clk) begin
        #1;
        bus_done  = 1'b0;
        bus_err   = 1'b0;
        bus_rdata = '0;
        if (b_pend) begin
            if (b_cnt == 0) begin
                bus_done = 1'b1;
                bus_err  = bad_addr(b_addr);
                if (b_isrd)
                    bus_rdata = b_mem.exists(int'(b_addr)) ? b_mem[int'(b_addr)] : dflt(b_addr);
                b_pend = 0;
            end else begin
                b_cnt--;
            end
        end else if (bus_re || bus_we) begin
            b_pend = 1;
            b_cnt  = lat;
            b_addr = bus_addr;
            b_isrd = bus_re;
            if (bus_we && !bad_addr(bus_addr)) b_mem[int'(bus_addr)] = bus_wdata;
        end
    end

    // ---------------- behavioural reference model ----------------
    logic [31:0] q[$];
    bit          qs[$];
    logic [31:0] m_mem [int];
    int          m_phase = 0;    // 0 idle, 1 waiting data, 2 bus access
    int          m_t = 0, m_t0 = 0;
    bit          m_isrd = 0, m_ovr = 0;
    logic [23:0] m_addr = '0;
    logic [31:0] m_wdat = '0;

    always @(posedge clk) begin
        bit busy_now, wr_x, rd_x;
        logic [7:0] op;
        if (!rst_n) begin
            q.delete(); qs.delete();
            m_phase = 0; m_t = 0; m_ovr = 0;
        end else begin
            wr_x = host_wr && !host_sel;
            rd_x = host_rd && !host_sel;
            busy_now = (m_phase == 2) || (q.size() > 0);
            if (rd_x && q.size() > 0) begin
                if (qs[0]) m_ovr = 0;
                void'(q.pop_front());
                void'(qs.pop_front());
            end
            if (m_phase == 2) begin
                m_t--;
                if (m_t == 0) begin
                    q.push_back(bad_addr(m_addr) ? 32'h1 : 32'h0);
                    qs.push_back(1);
                    if (m_isrd) begin
                        q.push_back(m_mem.exists(int'(m_addr)) ? m_mem[int'(m_addr)] : dflt(m_addr));
                        qs.push_back(0);
                    end
                    m_phase = 0;
                end
            end
            if (wr_x) begin
                if (busy_now) begin
                    m_ovr = 1;
                end else if (m_phase == 1) begin
                    m_wdat  = host_wdata;
                    m_phase = 2; m_t = lat + 2; m_t0 = m_t;
                    if (!bad_addr(m_addr)) m_mem[int'(m_addr)] = m_wdat;
                end else begin
                    op     = host_wdata[31:24];
                    m_addr = host_wdata[23:0];
                    if (op == 8'h01) begin
                        m_isrd = 1; m_phase = 2; m_t = lat + 2; m_t0 = m_t;
                    end else if (op == 8'h10) begin
                        m_isrd = 0; m_phase = 1;
                    end else begin
                        q.push_back(32'h2);
                        qs.push_back(1);
                    end
                end
            end
        end
    end

    // cycle-by-cycle comparison
    always @(negedge clk) begin
        logic [31:0] e_rd;
        bit e_re, e_we;
        if (rst_n) begin
            e_re = (m_phase == 2) && (m_t == m_t0) && m_isrd;
            e_we = (m_phase == 2) && (m_t == m_t0) && !m_isrd;
            if (host_sel)           e_rd = {31'b0, q.size() > 0};
            else if (q.size() > 0)  e_rd = q[0] | ((qs[0] && m_ovr) ? 32'h4 : 32'h0);
            else                    e_rd = 32'h0;
            chk("R5 host_rdata vs model", host_rdata, e_rd);
            chk("R2 bus_re vs model", {31'b0, bus_re}, {31'b0, e_re});
            chk("R2 bus_we vs model", {31'b0, bus_we}, {31'b0, e_we});
            if (e_re || e_we) chk("R1 bus_addr vs model", {8'h0, bus_addr}, {8'h0, m_addr});
            if (e_we)         chk("R2 bus_wdata vs model", bus_wdata, m_wdat);
        end
    end

    // ---------------- host tasks (start and end at posedge+1) ----------------
    task automatic hwr(input logic sel, input logic [31:0] w);
        host_sel = sel; host_wr = 1'b1; host_rd = 1'b0; host_wdata = w;
        @(posedge clk); #1;
        host_wr = 1'b0;
    endtask

    task automatic hrd(input logic sel, input logic [31:0] exp, input string tag);
        host_sel = sel; host_rd = 1'b1; host_wr = 1'b0;
        #2;
        chk(tag, host_rdata, exp);
        @(posedge clk); #1;
        host_rd = 1'b0;
    endtask

    task automatic peek(input logic sel, input logic [31:0] exp, input string tag);
        host_sel = sel; host_rd = 1'b0; host_wr = 1'b0;
        #2;
        chk(tag, host_rdata, exp);
        @(posedge clk); #1;
    endtask

    task automatic wait_ready();
        host_sel = 1'b1; host_rd = 1'b0; host_wr = 1'b0;
        for (int i = 0; i < 100; i++) begin
            #1;
            if (host_rdata[0]) break;
            @(posedge clk); #1;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #1_000_000;
        if (!done_f) begin
            errs++; checks++;
            $display("FAIL R5 watchdog: run did not complete, got hang expected finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        idle(2);
        #2;
        chk("R10 status reg in reset", host_rdata, 32'h0);
        chk("R10 no strobe in reset", {30'b0, bus_re, bus_we}, 32'h0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        idle(1);
        peek(1'b1, 32'h0, "R10 ready clear after reset");
        hrd(1'b0, 32'h0, "R10 transfer read idle returns 0");

        // plain read
        lat = 0;
        hwr(1'b0, 32'h0100_0123);
        wait_ready();
        @(posedge clk); #1;
        hrd(1'b0, 32'h0, "R6 read status ok");
        hrd(1'b0, dflt(24'h000123), "R5 read data follows status");
        peek(1'b1, 32'h0, "R4 ready clear after drain");

        // write then read back
        lat = 2;
        hwr(1'b0, 32'h1000_0040);
        peek(1'b1, 32'h0, "R2 no ready while waiting write data");
        hrd(1'b0, 32'h0, "R8 transfer read during data wait is inert");
        hwr(1'b0, 32'hDEAD_BEEF);
        wait_ready();
        @(posedge clk); #1;
        hrd(1'b0, 32'h0, "R5 write status only");
        peek(1'b1, 32'h0, "R5 no data word after write");
        lat = 1;
        hwr(1'b0, 32'h0100_0040);
        wait_ready();
        @(posedge clk); #1;
        hrd(1'b0, 32'h0, "R6 readback status");
        hrd(1'b0, 32'hDEAD_BEEF, "R2 readback of written word");

        // bus error
        hwr(1'b0, 32'h01F0_0010);
        wait_ready();
        @(posedge clk); #1;
        hrd(1'b0, 32'h1, "R6 bus error status bit0");
        hrd(1'b0, dflt(24'hF00010), "R5 data follows error status");

        // unknown opcode
        hwr(1'b0, 32'h5500_0001);
        peek(1'b1, 32'h1, "R3 ready next cycle for bad opcode");
        hrd(1'b0, 32'h2, "R3 bad opcode status");
        peek(1'b1, 32'h0, "R3 no data word for bad opcode");

        // overrun during bus access
        lat = 3;
        hwr(1'b0, 32'h0100_0200);
        hwr(1'b0, 32'h1000_0050);
        wait_ready();
        @(posedge clk); #1;
        hrd(1'b0, 32'h4, "R7 overrun flag in status");
        hrd(1'b0, dflt(24'h000200), "R7 data after overrun status");
        lat = 0;
        hwr(1'b0, 32'h0100_0050);
        wait_ready();
        @(posedge clk); #1;
        hrd(1'b0, 32'h0, "R7 overrun flag cleared");
        hrd(1'b0, dflt(24'h000050), "R7 ignored command wrote nothing");

        // overrun while response pending, then drain
        hwr(1'b0, 32'h0100_0300);
        wait_ready();
        @(posedge clk); #1;
        hwr(1'b0, 32'h0100_0999);
        peek(1'b0, 32'h4, "R7 pending status shows overrun");
        hrd(1'b0, 32'h4, "R8 drain first word");
        peek(1'b1, 32'h1, "R8 ready held with one word left");
        hrd(1'b0, dflt(24'h000300), "R8 drain second word");
        peek(1'b1, 32'h0, "R8 ready clear after drain");

        // status register write ignored
        hwr(1'b1, 32'h0100_0001);
        peek(1'b1, 32'h0, "R9 status write starts nothing");
        idle(3);
        peek(1'b1, 32'h0, "R9 ready still clear");

        // latency sweep
        for (int l = 0; l < 5; l++) begin
            lat = l;
            hwr(1'b0, 32'h1000_0000 | (l * 24'h10101));
            hwr(1'b0, 32'hA000_0000 + l);
            wait_ready();
            @(posedge clk); #1;
            hrd(1'b0, 32'h0, "R6 sweep write status");
            hwr(1'b0, 32'h0100_0000 | (l * 24'h10101));
            wait_ready();
            @(posedge clk); #1;
            hrd(1'b0, 32'h0, "R6 sweep read status");
            hrd(1'b0, 32'hA000_0000 + l, "R5 sweep read data");
        end

        idle(4);
        done_f = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule